// File: doc/BRIEF.md
# Trigger-Latency Sample Lookback Buffer

The block keeps the most recent samples of every calorimeter channel in a circular store while a level-1 decision is pending. Each sampling cycle, every channel's 16-bit sample goes into the next slot of that channel's ring. The write position advances by one slot per cycle, modulo the depth, and does not pause for anything but reset.

When an accept pulse is seen, the block fixes a start slot one programmed latency behind the current write slot. It then streams a short window of consecutive samples per channel to a downstream filter over a valid/ready interface. The order is channel-major, and the final beat of the event is flagged. Writing continues while the window is read out.

Only one event can be in flight at a time. An accept that arrives during a readout is dropped and leaves a sticky flag behind. The latency is a run-time input, so a longer trigger latency only needs a larger depth parameter, not new logic.

Top module: `trig_lookback_buf`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `out_valid`, `out_last` and `acc_lost` are low.
- R2: Accept seen at cycle T with latency L: the beat for channel c and window position k (k = 0..WIN-1) carries the sample presented on channel c in cycle T-L+k.
- R3: Channel c occupies bits [c*SW +: SW] of `smp_in`. Beat number b (from 0) carries channel b / WIN and position b % WIN, so every sample of channel 0 comes before any sample of channel 1, and so on.
- R4: `out_last` is high on beat NCH*WIN-1 and on no other beat. It is never high without `out_valid`. On the cycle after that beat is taken, `out_valid` is low.
- R5: A beat is taken only on a cycle with `out_valid` and `out_ready` both high. While `out_ready` is low, `out_valid`, `out_data` and `out_last` hold their values.
- R6: An accept seen while no readout is in progress makes `out_valid` high on the next cycle.
- R7: An accept seen while `out_valid` is high, including the cycle of the last beat, is dropped. It does not alter the event in flight and starts no new event. It sets `acc_lost`, which stays high until reset.
- R8: `lat_cfg` is sampled only in the cycle of an accepted trigger. Changing it during a readout has no effect on that event.
- R9: Sample writes continue every cycle during readout, and slot addresses wrap modulo DEPTH. A latency is legal when WIN <= L <= DEPTH-1 and the readout ends within DEPTH-L cycles of the accept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_in | input | NCH*SW | One sample per channel per cycle, channel c at bits [c*SW +: SW] |
| accept | input | 1 | Level-1 accept pulse |
| lat_cfg | input | $clog2(DEPTH) | Trigger latency in sample cycles |
| out_data | output | SW | Current beat's sample |
| out_valid | output | 1 | Beat available |
| out_ready | input | 1 | Downstream takes the beat |
| out_last | output | 1 | Final beat of the event |
| acc_lost | output | 1 | Sticky: an accept was dropped during a readout |

## Verification
`out_valid` rises one clock edge after an accepted trigger. From then on each beat's data and last flag come combinationally from registered state and the store, so a beat's value is present during the whole cycle in which it is current. A beat advances at the edge where valid and ready are both high, and `acc_lost` goes high at the edge after the offending accept. The bench drives every input on the falling edge and samples the outputs at the next falling edge, which is half a cycle after the edge that changed them. It counts the taken beats itself from the ready it drove and the valid it saw. It derives each expected sample from the cycle stamp it placed on that channel.

// File: rtl/trig_lookback_buf.sv
module trig_lookback_buf #(
  parameter int SW    = 16,
  parameter int NCH   = 16,
  parameter int DEPTH = 128,
  parameter int WIN   = 5,
  parameter int LW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH*SW-1:0] smp_in,
  input  logic              accept,
  input  logic [LW-1:0]     lat_cfg,
  output logic [SW-1:0]     out_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_last,
  output logic              acc_lost
);
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int KW = (WIN > 1) ? $clog2(WIN) : 1;
  localparam logic [LW:0] DEP_X = (LW+1)'(DEPTH);

  logic [LW-1:0] wp, base, raddr;
  logic [CW-1:0] ch;
  logic [KW-1:0] k;
  logic          busy;
  logic [LW:0]   wp_x, lat_x, start_x, rd_x;
  logic [SW-1:0] rd_bus [NCH];

  assign wp_x    = {1'b0, wp};
  assign lat_x   = {1'b0, lat_cfg};
  assign start_x = (wp_x >= lat_x) ? wp_x - lat_x : wp_x + DEP_X - lat_x;
  assign rd_x    = {1'b0, base} + (LW+1)'(k);
  assign raddr   = (rd_x >= DEP_X) ? LW'(rd_x - DEP_X) : LW'(rd_x);

  for (genvar c = 0; c < NCH; c++) begin : g_bank
    logic [SW-1:0] mem [DEPTH];
    always_ff @(posedge clk)
      if (rst_n) mem[wp] <= smp_in[c*SW +: SW];
    assign rd_bus[c] = mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) wp <= '0;
    else        wp <= (wp == LW'(DEPTH-1)) ? '0 : wp + 1'b1;
  end

  assign out_valid = busy;
  assign out_last  = busy && (ch == CW'(NCH-1)) && (k == KW'(WIN-1));
  assign out_data  = rd_bus[ch];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      acc_lost <= 1'b0;
      base     <= '0;
      ch       <= '0;
      k        <= '0;
    end else begin
      if (accept && busy) acc_lost <= 1'b1;
      if (accept && !busy) begin
        busy <= 1'b1;
        base <= LW'(start_x);
        ch   <= '0;
        k    <= '0;
      end
      if (busy && out_ready) begin
        if (out_last) begin
          busy <= 1'b0;
        end else if (k == KW'(WIN-1)) begin
          k  <= '0;
          ch <= ch + 1'b1;
        end else begin
          k <= k + 1'b1;
        end
      end
    end
  end
endmodule

module trig_lookback_buf_chk #(
  parameter int SW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          accept,
  input logic          out_valid,
  input logic          out_ready,
  input logic          out_last,
  input logic [SW-1:0] out_data,
  input logic          acc_lost
);
  assert_lost_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_lost |=> acc_lost);
  assert_lost_on_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && out_valid) |=> acc_lost);
  assert_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !out_valid) |=> out_valid);
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));
  assert_last_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);
  assert_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> !out_valid);
endmodule

bind trig_lookback_buf trig_lookback_buf_chk #(.SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .accept(accept), .out_valid(out_valid),
  .out_ready(out_ready), .out_last(out_last), .out_data(out_data),
  .acc_lost(acc_lost)
);

// File: tb/sim_trig_lookback_buf.sv
`timescale 1ns/1ps
module sim_trig_lookback_buf;
  localparam int SW = 16, NCH = 4, DEPTH = 64, WIN = 5;
  localparam int LW = $clog2(DEPTH);
  localparam int NB = NCH*WIN;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NCH*SW-1:0] smp_in = '0;
  logic              accept = 1'b0;
  logic [LW-1:0]     lat_cfg = '0;
  logic [SW-1:0]     out_data;
  logic              out_valid, out_ready = 1'b0, out_last, acc_lost;

  int errors = 0, checks = 0, t = 0;
  bit done = 0;

  always #4 clk = ~clk;

  trig_lookback_buf #(.SW(SW), .NCH(NCH), .DEPTH(DEPTH), .WIN(WIN)) u0 (
    .clk(clk), .rst_n(rst_n), .smp_in(smp_in), .accept(accept), .lat_cfg(lat_cfg),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_last(out_last), .acc_lost(acc_lost));

  function automatic logic [SW-1:0] stamp(input int c, input int n);
    return {4'(c), 12'(n)};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at t=%0d", req, act, exp, t);
    end
  endtask

  task automatic drive_samples();
    for (int c = 0; c < NCH; c++) smp_in[c*SW +: SW] = stamp(c, t);
    t++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      accept = 1'b0; out_ready = 1'b0;
      drive_samples();
    end
  endtask

  task automatic run_event(input int lat, input int mode, input bit try_lost, input int new_lat);
    int tacc, b, cyc;
    bit fire;
    @(negedge clk);
    tacc = t; accept = 1'b1; lat_cfg = LW'(lat); out_ready = 1'b0;
    drive_samples();
    b = 0; cyc = 0; fire = 0;
    while (cyc < 400) begin
      @(negedge clk);
      if (fire) b++;
      if (b == NB) break;
      if (cyc == 0) check(out_valid === 1'b1, "R6 valid after accept", 32'(out_valid), 1);
      else          check(out_valid === 1'b1, "R5 valid held until last", 32'(out_valid), 1);
      check(out_data === stamp(b / WIN, tacc - lat + b % WIN), "R2 R3 beat data",
            32'(out_data), 32'(stamp(b / WIN, tacc - lat + b % WIN)));
      check(out_last === (b == NB-1), "R4 last flag", 32'(out_last), 32'(b == NB-1));
      accept = try_lost && (cyc == 3);
      lat_cfg = LW'(new_lat);
      out_ready = (mode == 0) ? 1'b1 : (cyc % 3 != 2);
      fire = out_ready;
      drive_samples();
      cyc++;
    end
    check(b == NB && out_valid === 1'b0, "R4 valid low after last beat", 32'(out_valid), 0);
    accept = 1'b0; out_ready = 1'b0; drive_samples();
  endtask

  initial begin
    idle(3);
    check(out_valid === 1'b0 && out_last === 1'b0 && acc_lost === 1'b0, "R1 reset outputs",
          {29'd0, out_valid, out_last, acc_lost}, 0);
    @(negedge clk); rst_n = 1'b1; drive_samples();
    @(negedge clk); drive_samples();
    check(out_valid === 1'b0 && acc_lost === 1'b0, "R1 first cycle after reset",
          {30'd0, out_valid, acc_lost}, 0);
    idle(70);
    // R9: latency sweep with wrap-around; R8: lat_cfg moved mid-readout
    for (int lat = WIN; lat <= 24; lat++) begin
      run_event(lat, lat % 2, 1'b0, (lat + 7) % DEPTH);
      idle(20 + (lat * 3) % 17);
    end
    check(acc_lost === 1'b0, "R7 no drop without overlap", 32'(acc_lost), 0);
    run_event(10, 1, 1'b1, 3);
    check(acc_lost === 1'b1, "R7 drop flagged", 32'(acc_lost), 1);
    idle(6);
    check(out_valid === 1'b0, "R7 dropped accept starts nothing", 32'(out_valid), 0);
    check(acc_lost === 1'b1, "R7 flag sticky", 32'(acc_lost), 1);
    @(negedge clk); rst_n = 1'b0; accept = 1'b0; drive_samples();
    @(negedge clk); drive_samples();
    check(acc_lost === 1'b0 && out_valid === 1'b0, "R1 reset clears flag",
          {30'd0, acc_lost, out_valid}, 0);
    @(negedge clk); rst_n = 1'b1; drive_samples();
    idle(40);
    run_event(WIN, 0, 1'b0, 30);
    run_event(7, 0, 1'b0, 9);
    idle(3);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule